// File: doc/BRIEF.md
# Lane-Sliced Wide Trace Buffer

This block keeps a circular history of wide trace records and lets a narrow register port read it back. A capture side presents one full-width record per strobe; the record is stored at the current capture position, which then steps forward and wraps at the end of the storage. Old records are overwritten, so the buffer always holds the most recent history.

Software reads the history one 32-bit slice at a time. It picks a slice (a lane) in the lane register, loads the read position, usually with the current capture position so that the oldest record comes first, and then reads the data register repeatedly. Every data read returns the chosen lane of the record at the read position and moves the read position on by one. After a full pass over every entry the read position is back where it started, so software can switch lane, reload the position and sweep again.

Top module: `lane_trace_buf`

## Requirements
- R1: After a synchronous active-low reset, the lane register, the read position and the capture position are all 0, and reading any of them returns 0.
- R2: Each cycle with `cap_valid` high stores `cap_data` at the capture position and advances it by one modulo DEPTH (512 by default); the capture position never moves otherwise.
- R3: A register write to offset 1 loads the read position from the low log2(DEPTH) bits of `reg_wdata`; a read of offset 1 returns the read position.
- R4: A register read of offset 2 returns, in `reg_rdata` from the cycle after the read strobe, bits [32*L+31 : 32*L] of the record stored at the read position, where L is the lane register value.
- R5: Each read of offset 2 advances the read position by one modulo DEPTH.
- R6: A register write to offset 0 loads the lane register from `reg_wdata[2:0]` (lanes 0 to 7) and moves neither the read nor the capture position; a read of offset 0 returns the lane.
- R7: Register writes to offsets 2 and 3 have no effect on any state.
- R8: Reads of offsets 0, 1 and 3 do not move the read position; a read of offset 3 returns the capture position.
- R9: Loading the read position with the capture position and reading DEPTH times returns the stored records oldest first, including after the capture position has wrapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cap_valid | input | 1 | Store `cap_data` this cycle |
| cap_data | input | 256 | Record to capture |
| reg_addr | input | 2 | Word offset: 0 lane, 1 read position, 2 data, 3 capture position |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Read result, valid the cycle after `reg_rd`, held until the next read |

## Verification
The assertions assume `reg_wr` and `reg_rd` are never high in the same cycle, and that the storage is not read at the entry being captured in that same cycle; the bench drives one register access at a time and finishes all capture before it reads. Pointer stepping is asserted as plus one modulo the pointer width, which relies on DEPTH being a power of two; the bench keeps the default depth. Wrap-around is exercised by capturing more than DEPTH records and sweeping the whole buffer.

// File: rtl/tlb_pkg.sv
// Shared definitions for the lane-sliced trace buffer.
// Assumes a two-bit register word offset.
package tlb_pkg;
    typedef enum logic [1:0] {
        OFS_LANE  = 2'd0,
        OFS_RDPOS = 2'd1,
        OFS_DATA  = 2'd2,
        OFS_WRPOS = 2'd3
    } tlb_ofs_e;
endpackage

// File: rtl/tlb_store.sv
// Record storage: one write port for capture, one registered read port.
// Assumes read and write never target the same entry in the same cycle.
module tlb_store #(
    parameter int DEPTH = 512,
    parameter int REC_W = 256,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [REC_W-1:0] wdata,
    input  logic             re,
    input  logic [PTR_W-1:0] raddr,
    output logic [REC_W-1:0] rdata
);
    logic [REC_W-1:0] mem [DEPTH];

    // Capture write into the array.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read of a whole record.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/tlb_ptr_ctl.sv
// Capture and read positions. Both wrap naturally; DEPTH must be a power of two.
module tlb_ptr_ctl #(
    parameter int DEPTH = 512,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_step,
    input  logic             rd_load,
    input  logic [PTR_W-1:0] rd_load_val,
    input  logic             rd_step,
    output logic [PTR_W-1:0] wr_pos,
    output logic [PTR_W-1:0] rd_pos
);
    // Capture position steps on every captured record.
    always_ff @(posedge clk) begin
        if (!rst_n)        wr_pos <= '0;
        else if (cap_step) wr_pos <= wr_pos + PTR_W'(1);
    end

    // Read position loads from software or steps on each data read.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_pos <= '0;
        else if (rd_load) rd_pos <= rd_load_val;
        else if (rd_step) rd_pos <= rd_pos + PTR_W'(1);
    end
endmodule

// File: rtl/tlb_lane_mux.sv
// Picks one LANE_W slice out of a record by lane number.
module tlb_lane_mux #(
    parameter int REC_W  = 256,
    parameter int LANE_W = 32,
    localparam int NLANE  = REC_W / LANE_W,
    localparam int LSEL_W = $clog2(NLANE)
) (
    input  logic [REC_W-1:0]  rec,
    input  logic [LSEL_W-1:0] sel,
    output logic [LANE_W-1:0] slice
);
    logic [LANE_W-1:0] lanes [NLANE];

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign lanes[g] = rec[g*LANE_W +: LANE_W];
    end

    // Select the requested lane.
    always_comb slice = lanes[sel];
endmodule

// File: rtl/lane_trace_buf.sv
// Top of the lane-sliced trace buffer: register decode, lane register,
// read-result staging. Assumes reg_wr and reg_rd are never both high.
module lane_trace_buf #(
    parameter int DEPTH  = 512,
    parameter int REC_W  = 256,
    parameter int REG_W  = 32,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int NLANE  = REC_W / REG_W,
    localparam int LSEL_W = $clog2(NLANE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_valid,
    input  logic [REC_W-1:0] cap_data,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             reg_rd,
    output logic [REG_W-1:0] reg_rdata
);
    import tlb_pkg::*;

    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [LSEL_W-1:0] lane;
    logic              data_rd;
    logic              rdpos_wr;
    logic [REC_W-1:0]  rec_q;
    logic [REG_W-1:0]  slice;
    logic [LSEL_W-1:0] lane_q;
    logic              from_data_q;
    logic [REG_W-1:0]  small_q;

    // Decode the strobes that touch the read position.
    always_comb begin
        data_rd  = reg_rd && (tlb_ofs_e'(reg_addr) == OFS_DATA);
        rdpos_wr = reg_wr && (tlb_ofs_e'(reg_addr) == OFS_RDPOS);
    end

    tlb_store #(.DEPTH(DEPTH), .REC_W(REC_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cap_valid),
        .waddr (wr_ptr),
        .wdata (cap_data),
        .re    (data_rd),
        .raddr (rd_ptr),
        .rdata (rec_q)
    );

    tlb_ptr_ctl #(.DEPTH(DEPTH)) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_step    (cap_valid),
        .rd_load     (rdpos_wr),
        .rd_load_val (reg_wdata[PTR_W-1:0]),
        .rd_step     (data_rd),
        .wr_pos      (wr_ptr),
        .rd_pos      (rd_ptr)
    );

    // Lane register, written at offset 0 only.
    always_ff @(posedge clk) begin
        if (!rst_n) lane <= '0;
        else if (reg_wr && (tlb_ofs_e'(reg_addr) == OFS_LANE))
            lane <= reg_wdata[LSEL_W-1:0];
    end

    // Stage the result of each read for the following cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q      <= '0;
            from_data_q <= 1'b0;
            small_q     <= '0;
        end else if (reg_rd) begin
            lane_q      <= lane;
            from_data_q <= data_rd;
            unique case (tlb_ofs_e'(reg_addr))
                OFS_LANE:  small_q <= REG_W'(lane);
                OFS_RDPOS: small_q <= REG_W'(rd_ptr);
                OFS_WRPOS: small_q <= REG_W'(wr_ptr);
                default:   small_q <= '0;
            endcase
        end
    end

    tlb_lane_mux #(.REC_W(REC_W), .LANE_W(REG_W)) u_mux (
        .rec   (rec_q),
        .sel   (lane_q),
        .slice (slice)
    );

    // Present either the record slice or the staged register value.
    always_comb reg_rdata = from_data_q ? slice : small_q;
endmodule

// File: rtl/tlb_checker.sv
// Temporal checks on the trace buffer pointers and lane register.
// Assumes DEPTH is a power of two and reg_wr/reg_rd are exclusive.
module tlb_checker #(
    parameter int PTR_W  = 9,
    parameter int LSEL_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cap_valid,
    input logic [1:0]        reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [PTR_W-1:0]  wr_ptr,
    input logic [PTR_W-1:0]  rd_ptr,
    input logic [LSEL_W-1:0] lane
);
    // R2: a capture advances the capture position by one, modulo depth.
    a_r2_wr_advance: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> wr_ptr == PTR_W'($past(wr_ptr) + PTR_W'(1)));

    // R2, R7: without capture the capture position holds, whatever is written.
    a_r7_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_valid |=> $stable(wr_ptr));

    // R5: a data read advances the read position.
    a_r5_rd_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd2) |=> rd_ptr == PTR_W'($past(rd_ptr) + PTR_W'(1)));

    // R8, R6: no data read and no position load leaves the read position alone.
    a_r8_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(reg_rd && reg_addr == 2'd2) && !(reg_wr && reg_addr == 2'd1)) |=> $stable(rd_ptr));

    // R6, R7: the lane changes only on a write to offset 0.
    a_r6_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == 2'd0) |=> $stable(lane));

    // Access protocol assumption: never a read and a write together.
    a_r4_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));
endmodule

bind lane_trace_buf tlb_checker #(.PTR_W(PTR_W), .LSEL_W(LSEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_valid (cap_valid),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .lane      (lane)
);

// File: tb/tb_lane_trace_buf.sv
module tb_lane_trace_buf;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 512;
    localparam int REC_W = 256;
    localparam int FILL  = 20;

    // Vector: {start position 9b, lane 3b, expected data 32b}
    localparam int NVEC = 6;
    localparam logic [43:0] VEC [NVEC] = '{
        {9'd3,  3'd0, 32'h00A50003},
        {9'd7,  3'd5, 32'h05A50007},
        {9'd19, 3'd7, 32'h07A50013},
        {9'd0,  3'd2, 32'h02A50000},
        {9'd12, 3'd1, 32'h01A5000C},
        {9'd8,  3'd6, 32'h06A50008}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cap_valid = 1'b0;
    logic [REC_W-1:0] cap_data = '0;
    logic [1:0]       reg_addr = '0;
    logic             reg_wr = 1'b0;
    logic [31:0]      reg_wdata = '0;
    logic             reg_rd = 1'b0;
    logic [31:0]      reg_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_trace_buf dut (
        .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_data(cap_data),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    function automatic logic [REC_W-1:0] make_rec(input int idx);
        logic [REC_W-1:0] r;
        for (int k = 0; k < 8; k++) r[k*32 +: 32] = {8'(k), 8'hA5, 16'(idx)};
        return r;
    endfunction

    function automatic logic [31:0] lane_word(input int idx, input int ln);
        return {8'(ln), 8'hA5, 16'(idx)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic capture(input int idx);
        @(negedge clk);
        cap_data = make_rec(idx); cap_valid = 1'b1;
        @(negedge clk);
        cap_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] pos;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        reg_read(2'd0, v); check("R1 lane", v, 32'd0);
        reg_read(2'd1, v); check("R1 rdpos", v, 32'd0);
        reg_read(2'd3, v); check("R1 wrpos", v, 32'd0);

        for (int i = 0; i < FILL; i++) capture(i);
        reg_read(2'd3, v); check("R2 wrpos after fill", v, 32'(FILL));

        // R3, R4, R5, R6: vector table
        for (int n = 0; n < NVEC; n++) begin
            reg_write(2'd0, 32'(VEC[n][34:32]));
            reg_write(2'd1, 32'(VEC[n][43:35]));
            reg_read(2'd1, v); check("R3 rdpos load", v, 32'(VEC[n][43:35]));
            reg_read(2'd2, v); check("R4 data slice", v, VEC[n][31:0]);
            reg_read(2'd1, v); check("R5 rdpos step", v, 32'(VEC[n][43:35]) + 32'd1);
            reg_read(2'd0, v); check("R6 lane readback", v, 32'(VEC[n][34:32]));
        end

        // R6: lane change keeps read position; next data read sees new lane
        reg_write(2'd1, 32'd4);
        reg_write(2'd0, 32'd3);
        reg_read(2'd1, v); check("R6 rdpos unchanged", v, 32'd4);
        reg_read(2'd3, v); check("R6 wrpos unchanged", v, 32'(FILL));
        reg_read(2'd2, v); check("R6 new lane data", v, lane_word(4, 3));

        // R7: writes to data and capture-position offsets ignored
        reg_write(2'd2, 32'hFFFF_FFFF);
        reg_write(2'd3, 32'd100);
        reg_read(2'd3, v); check("R7 wrpos kept", v, 32'(FILL));
        reg_read(2'd1, v); check("R7 rdpos kept", v, 32'd5);
        reg_read(2'd0, v); check("R7 lane kept", v, 32'd3);
        reg_read(2'd2, v); check("R7 data intact", v, lane_word(5, 3));

        // R8: non-data reads do not move the read position
        reg_read(2'd0, v);
        reg_read(2'd3, v);
        reg_read(2'd1, v); check("R8 rdpos still", v, 32'd6);

        // R2, R9: wrap the capture position, then sweep oldest first
        for (int i = FILL; i < DEPTH + 5; i++) capture(i);
        reg_read(2'd3, pos); check("R2 wrpos wrapped", pos, 32'd5);
        reg_write(2'd0, 32'd1);
        reg_write(2'd1, pos);
        for (int n = 0; n < DEPTH; n++) begin
            int e;
            int idx;
            e = (5 + n) % DEPTH;
            idx = (e < 5) ? e + DEPTH : e;
            reg_read(2'd2, v); check("R9 sweep", v, lane_word(idx, 1));
        end
        reg_read(2'd1, v); check("R5 rdpos wrapped full pass", v, 32'd5);

        finish_run();
    end
endmodule